// File: doc/BRIEF.md
# Stream Frame Increment Buffer

This block takes fixed-length frames of wide words from a streaming source and returns each frame with every word increased by one. Words arrive one per handshake on a ready/valid slave port and shift into a capture bank. When the bank holds a whole frame, one cycle adds one to every word at once and copies the sums into a replay bank. The replay bank then shifts the words out on a ready/valid master port, in arrival order.

The block handles one frame at a time. Capture, a single load cycle and replay follow each other. While the replay runs, the slave port is closed to new input. The downstream sink may pull its ready low at any cycle of the replay. The block then holds the current word, the end-of-frame flag and its shift position. It never puts a placeholder word on the output and never skips a word.

The controller has three states. **RECEIVE** accepts input and moves to **LOAD** on the handshake of the last word of the frame. **LOAD** always moves to **SEND** after one cycle. **SEND** moves back to **RECEIVE** on the handshake of the last output word. A synchronous reset forces **RECEIVE** from any state.

Top module: `frame_inc_buffer`

## Requirements
- R1: A frame is FRAME_LEN words of DATA_W bits, with defaults of 300 and 64. An input word is accepted on a clock edge where in_valid and in_ready are both high, and in_ready is high in RECEIVE.
- R2: After the FRAME_LEN-th accepted word, in_ready is low in the next cycle. Before that word it stays high. The level of in_last never moves the frame boundary.
- R3: The cycle after the last input word is accepted, in_ready and out_valid are both low (LOAD). In the cycle after that, out_valid is high.
- R4: Each output word equals its input word plus one, modulo 2^DATA_W. An all-ones word comes out as zero.
- R5: Output words leave in the same order in which the input words arrived.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data and out_last do not change in the next cycle. No word is lost or repeated.
- R7: out_last is high with the FRAME_LEN-th output word and low with every other output word.
- R8: in_ready is low during LOAD and SEND. in_valid and in_data have no effect on the frame being replayed or on the frame that follows.
- R9: After the handshake of the word carrying out_last, the next cycle has in_ready high and out_valid low.
- R10: A synchronous reset brings out_valid low and in_ready high. Any partly received frame is discarded, so the next frame starts counting from its first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Input word |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block accepts an input word |
| in_last | input | 1 | Source end-of-frame marker, not used for framing |
| out_data | output | DATA_W | Incremented output word |
| out_valid | output | 1 | Output word is present |
| out_ready | input | 1 | Sink accepts the output word |
| out_last | output | 1 | Marks the final word of an output frame |

## Verification
The bench uses a short frame of 16-bit words. It sweeps data patterns against every combination of sink stall pattern and source gap pattern. The data patterns include all-ones words, which must wrap to zero, and zero words. A design that lets its output slip while the sink stalls would show a zero or the next word early. A design that advances without a handshake would skip a word. Either way the word-by-word comparison fails. The in_last marker is sent on time, early and not at all, which catches a design that cuts the frame on it. in_valid is held high with junk data during replay, which catches a design that takes input while it sends. A reset in the middle of a frame, followed by a full frame, catches a counter that survives the reset.

// File: rtl/fib_pkg.sv
package fib_pkg;
    typedef enum logic [1:0] {
        ST_RECV = 2'd0,
        ST_LOAD = 2'd1,
        ST_SEND = 2'd2
    } fib_state_e;
endpackage

// File: rtl/fib_ctrl.sv
// Frame sequencer: RECEIVE -> LOAD -> SEND -> RECEIVE, one shared word index.
module fib_ctrl
    import fib_pkg::*;
#(
    parameter int FRAME_LEN = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic out_last,
    output logic capture,
    output logic load,
    output logic advance
);
    localparam int CW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_LEN - 1);

    fib_state_e state_q, state_d;
    logic [CW-1:0] idx_q;
    logic at_last;

    assign at_last = (idx_q == LAST_IDX);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RECV;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RECV: if (capture && at_last) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_SEND;
            ST_SEND: if (advance && at_last) state_d = ST_RECV;
            default: state_d = ST_RECV;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        capture   = 1'b0;
        load      = 1'b0;
        advance   = 1'b0;
        unique case (state_q)
            ST_RECV: begin
                in_ready = 1'b1;
                capture  = in_valid;
            end
            ST_LOAD: load = 1'b1;
            ST_SEND: begin
                out_valid = 1'b1;
                out_last  = at_last;
                advance   = out_ready;
            end
            default: ;
        endcase
    end

    // word index, moves only on a handshake
    always_ff @(posedge clk) begin
        if (rst)                       idx_q <= '0;
        else if (capture || advance)   idx_q <= at_last ? '0 : idx_q + 1'b1;
    end
endmodule

// File: rtl/fib_sipo.sv
// Capture bank: newest word enters at the top, oldest ends at index 0.
module fib_sipo #(
    parameter int DATA_W    = 64,
    parameter int FRAME_LEN = 300
) (
    input  logic                               clk,
    input  logic                               shift_en,
    input  logic [DATA_W-1:0]                  din,
    output logic [FRAME_LEN-1:0][DATA_W-1:0]   bank
);
    always_ff @(posedge clk) begin
        if (shift_en) bank <= {din, bank[FRAME_LEN-1:1]};
    end
endmodule

// File: rtl/fib_inc.sv
// One adder per word, all in parallel; carries out of the top bit are dropped.
module fib_inc #(
    parameter int DATA_W    = 64,
    parameter int FRAME_LEN = 300
) (
    input  logic [FRAME_LEN-1:0][DATA_W-1:0] a,
    output logic [FRAME_LEN-1:0][DATA_W-1:0] y
);
    for (genvar g = 0; g < FRAME_LEN; g++) begin : g_add
        assign y[g] = a[g] + DATA_W'(1);
    end
endmodule

// File: rtl/fib_piso.sv
// Replay bank: parallel load, head word at index 0, shifts only on advance.
module fib_piso #(
    parameter int DATA_W    = 64,
    parameter int FRAME_LEN = 300
) (
    input  logic                               clk,
    input  logic                               load,
    input  logic                               advance,
    input  logic [FRAME_LEN-1:0][DATA_W-1:0]   par_in,
    output logic [DATA_W-1:0]                  head
);
    logic [FRAME_LEN-1:0][DATA_W-1:0] bank;

    always_ff @(posedge clk) begin
        if (load)         bank <= par_in;
        else if (advance) bank <= {bank[FRAME_LEN-1], bank[FRAME_LEN-1:1]};
    end

    assign head = bank[0];
endmodule

// File: rtl/frame_inc_buffer.sv
module frame_inc_buffer #(
    parameter int DATA_W    = 64,
    parameter int FRAME_LEN = 300
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_last,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_last
);
    logic capture, load, advance;
    logic [FRAME_LEN-1:0][DATA_W-1:0] captured;
    logic [FRAME_LEN-1:0][DATA_W-1:0] bumped;

    fib_ctrl #(.FRAME_LEN(FRAME_LEN)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_last  (out_last),
        .capture   (capture),
        .load      (load),
        .advance   (advance)
    );

    fib_sipo #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) u_sipo (
        .clk      (clk),
        .shift_en (capture),
        .din      (in_data),
        .bank     (captured)
    );

    fib_inc #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) u_inc (
        .a (captured),
        .y (bumped)
    );

    fib_piso #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) u_piso (
        .clk     (clk),
        .load    (load),
        .advance (advance),
        .par_in  (bumped),
        .head    (out_data)
    );
endmodule

// File: rtl/fib_checks.sv
module fib_checks #(
    parameter int DATA_W    = 64,
    parameter int FRAME_LEN = 300
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_last,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_last
);
    localparam int CW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_LEN - 1);

    logic [CW-1:0] in_cnt, out_cnt;
    logic in_hs, out_hs;
    assign in_hs  = in_valid && in_ready;
    assign out_hs = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_cnt  <= '0;
            out_cnt <= '0;
        end else begin
            if (in_hs)  in_cnt  <= (in_cnt  == LAST_IDX) ? '0 : in_cnt  + 1'b1;
            if (out_hs) out_cnt <= (out_cnt == LAST_IDX) ? '0 : out_cnt + 1'b1;
        end
    end

    assert_frame_end_R2: assert property (@(posedge clk) disable iff (rst)
        (in_hs && in_cnt == LAST_IDX) |=> !in_ready);

    assert_mid_frame_open_R2: assert property (@(posedge clk) disable iff (rst)
        (in_hs && in_cnt != LAST_IDX) |=> in_ready);

    assert_tlast_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (in_hs && in_last && in_cnt != LAST_IDX) |=> in_ready);

    assert_load_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (in_hs && in_cnt == LAST_IDX) |=> (!in_ready && !out_valid) ##1 out_valid);

    assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_last_position_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_last == (out_cnt == LAST_IDX)));

    assert_closed_while_sending_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    assert_return_to_receive_R9: assert property (@(posedge clk) disable iff (rst)
        (out_hs && out_last) |=> (in_ready && !out_valid));
endmodule

bind frame_inc_buffer fib_checks #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last)
);

// File: tb/frame_inc_buffer_test.sv
`timescale 1ns/1ps
module frame_inc_buffer_test;
    localparam int W = 16;
    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] in_data = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_last = 1'b0;
    logic [W-1:0] out_data;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic         out_last;

    int n_checks = 0;
    int n_fail   = 0;
    logic [W-1:0] frame_q [N];
    logic [15:0]  lfsr_q = 16'hACE1;

    always #2 clk = ~clk;

    frame_inc_buffer #(.DATA_W(W), .FRAME_LEN(N)) uut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .in_last(in_last), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step_lfsr();
        lfsr_q = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    endtask

    task automatic make_frame(input int dmode, input int f);
        for (int k = 0; k < N; k++) begin
            case (dmode)
                0: frame_q[k] = W'(k * 3 + f);
                1: frame_q[k] = '1;
                2: frame_q[k] = W'(16'hFFFF - k);
                3: begin step_lfsr(); frame_q[k] = lfsr_q; end
                default: frame_q[k] = '0;
            endcase
        end
    endtask

    // ends at the first SEND-cycle negedge, with junk held on the input
    task automatic send_frame(input int gap, input int lmode);
        for (int k = 0; k < N; k++) begin
            if (gap != 0 && (k % 2) == 1) begin
                in_valid = 1'b0;
                repeat (2) @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = frame_q[k];
            in_last  = (lmode == 0) ? (k == N - 1) : (lmode == 2) ? (k == 1) : 1'b0;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b1;
        in_data  = 16'h0BAD;
        in_last  = 1'b1;
        check(!in_ready && !out_valid, "R3 load cycle idle", {in_ready, out_valid}, 0);
        @(negedge clk);
        check(out_valid, "R3 out_valid after load", out_valid, 1);
    endtask

    function automatic bit ready_fn(input int rmode, input int cyc);
        case (rmode)
            0: return 1'b1;
            1: return cyc[0];
            2: return lfsr_q[3];
            default: return (cyc % 4) == 3;
        endcase
    endfunction

    task automatic recv_frame(input int rmode);
        int k = 0;
        int cyc = 0;
        while (k < N) begin
            if (rmode == 2) step_lfsr();
            out_ready = ready_fn(rmode, cyc);
            check(out_valid, "R6 valid held", out_valid, 1);
            check(out_data == W'(frame_q[k] + 1), "R4 R5 R6 word value/order", out_data, W'(frame_q[k] + 1));
            check(!in_ready, "R8 input closed", in_ready, 0);
            if (out_ready) begin
                check(out_last == (k == N - 1), "R7 last flag", out_last, (k == N - 1));
                k++;
            end
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b0;
        in_valid  = 1'b0;
        in_last   = 1'b0;
        check(in_ready && !out_valid, "R9 back to receive", {in_ready, out_valid}, 2'b10);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready, "R10 reset state", {in_ready, out_valid}, 2'b10);
        check(in_ready, "R1 ready in receive", in_ready, 1);

        // mid-frame reset discards the partial frame
        for (int k = 0; k < 2; k++) begin
            in_valid = 1'b1;
            in_data  = 16'h5555;
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready, "R10 reset mid-frame", {in_ready, out_valid}, 2'b10);
        make_frame(0, 7);
        send_frame(0, 0);
        recv_frame(0);

        // sweep data patterns x sink stall patterns x source gaps x in_last placement
        for (int d = 0; d < 5; d++) begin
            for (int r = 0; r < 4; r++) begin
                make_frame(d, d * 4 + r);
                send_frame((d + r) % 2, r % 3);
                recv_frame(r);
            end
        end

        // the R2 boundary: early in_last does not end the frame
        make_frame(3, 0);
        send_frame(1, 2);
        recv_frame(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule